// File: doc/BRIEF.md
# Dual-Mode Pixel Array Readout Scanner

This block sequences the readout of a square array of analogue pixels (48 by 48 by default). It drives one-hot row and column select lines and two scan markers. All state moves only on cycles where the pixel-clock enable is high. The mode that applies is the level of the mode input on that enable cycle.

In probe mode, a vertical (row) address and a horizontal (column) address are decoded into one-hot selects. That pixel stays selected until a later enable brings a different address, so its output can be watched for as long as needed. In scan mode, the column selector acts as a rotating one-hot register that moves one column per enable. The row selector moves one row each time the column selector wraps. The whole image therefore streams out in raster order for a television-style display. Line-start and frame-start markers identify the first pixel of each row and of each frame.

Top module: `pixel_scan_sequencer`

## Requirements
- R1: After reset the block is in probe mode with row 0 and column 0 selected (bit 0 of each select vector high), and line_start and frame_start are low.
- R2: row_sel and col_sel each have exactly one bit high in every cycle.
- R3: Selects, markers and the registered mode change only in the cycle after a clock edge at which pix_en is high. Without pix_en they hold.
- R4: On an enable cycle with scan_mode low, row_addr and col_addr are decoded so that bit row_addr of row_sel and bit col_addr of col_sel are high from the next cycle on. The selection holds until the next enable, even if the addresses change.
- R5: In probe mode, an address of 48 or more selects index 47 (the last row or column).
- R6: The first enable with scan_mode high while the block is in probe mode selects row 0 and column 0, starting a frame.
- R7: On each later enable with scan_mode high, the column select moves from bit k to bit k+1, and the row select stays unchanged unless the column wraps.
- R8: When the column select is at bit 47 and a scan enable occurs, it returns to bit 0 and the row select moves up by one. From row 47 it returns to row 0.
- R9: line_start is high exactly when the block is in scan mode and bit 0 of col_sel is high. frame_start is high exactly when line_start is high and bit 0 of row_sel is high. In probe mode both are low.
- R10: A change of scan_mode without pix_en has no effect on any output. The new mode applies from the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel period per high cycle |
| scan_mode | input | 1 | 1 = raster scan, 0 = single-pixel probe |
| row_addr | input | 6 | Probe row address |
| col_addr | input | 6 | Probe column address |
| row_sel | output | 48 | One-hot row select |
| col_sel | output | 48 | One-hot column select |
| line_start | output | 1 | Scan at column 0 |
| frame_start | output | 1 | Scan at row 0, column 0 |

## Verification
The assertions assume that reset is applied before the first enable, and that scan_mode, pix_en and both addresses are stable around each rising edge. No X reaches these inputs. The bench changes every input only on falling edges and holds rst_n low over the first edges. Its addresses range over the full 6-bit space, including values above 47, so that the clamp assertion is exercised by legal inputs only.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic {
        MODE_PROBE = 1'b0,
        MODE_SCAN  = 1'b1
    } scan_mode_e;
endpackage

// File: rtl/pss_addr_decode.sv
// Clamped binary-to-one-hot decoder for the probe addresses.
module pss_addr_decode #(
    parameter int N  = 48,
    parameter int AW = 6
) (
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  sel
);
    localparam int LAST = N - 1;

    int idx;

    always_comb begin
        if (int'(addr) > LAST) idx = LAST;
        else                   idx = int'(addr);
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        assign sel[gi] = (idx == gi);
    end
endmodule

// File: rtl/pss_ring_step.sv
// Next value of a rotating one-hot selector.
module pss_ring_step #(
    parameter int N = 48
) (
    input  logic [N-1:0] cur,
    input  logic         load,
    input  logic         adv,
    output logic [N-1:0] nxt
);
    localparam logic [N-1:0] FIRST = N'(1);

    always_comb begin
        if (load)     nxt = FIRST;
        else if (adv) nxt = {cur[N-2:0], cur[N-1]};
        else          nxt = cur;
    end
endmodule

// File: rtl/pixel_scan_sequencer.sv
module pixel_scan_sequencer
    import pss_pkg::*;
#(
    parameter int ROWS = 48,
    parameter int COLS = 48
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     pix_en,
    input  logic                                     scan_mode,
    input  logic [$clog2(ROWS > COLS ? ROWS : COLS)-1:0] row_addr,
    input  logic [$clog2(ROWS > COLS ? ROWS : COLS)-1:0] col_addr,
    output logic [ROWS-1:0]                          row_sel,
    output logic [COLS-1:0]                          col_sel,
    output logic                                     line_start,
    output logic                                     frame_start
);
    localparam int MAXD = (ROWS > COLS) ? ROWS : COLS;
    localparam int AW   = $clog2(MAXD);

    typedef struct packed {
        scan_mode_e      mode;
        logic [ROWS-1:0] row;
        logic [COLS-1:0] col;
    } state_t;

    localparam state_t RESET_ST = '{mode: MODE_PROBE, row: ROWS'(1), col: COLS'(1)};

    state_t st_d, st_q;

    logic [ROWS-1:0] row_dec, row_step;
    logic [COLS-1:0] col_dec, col_step;
    logic            entering, scanning, col_last;

    assign entering = scan_mode && (st_q.mode == MODE_PROBE);
    assign scanning = scan_mode && (st_q.mode == MODE_SCAN);
    assign col_last = st_q.col[COLS-1];

    pss_addr_decode #(.N(ROWS), .AW(AW)) u_row_dec (.addr(row_addr), .sel(row_dec));
    pss_addr_decode #(.N(COLS), .AW(AW)) u_col_dec (.addr(col_addr), .sel(col_dec));

    pss_ring_step #(.N(COLS)) u_col_ring (
        .cur (st_q.col),
        .load(entering),
        .adv (scanning),
        .nxt (col_step)
    );

    pss_ring_step #(.N(ROWS)) u_row_ring (
        .cur (st_q.row),
        .load(entering),
        .adv (scanning && col_last),
        .nxt (row_step)
    );

    always_comb begin
        st_d = st_q;
        if (pix_en) begin
            st_d.mode = scan_mode ? MODE_SCAN : MODE_PROBE;
            if (scan_mode) begin
                st_d.row = row_step;
                st_d.col = col_step;
            end else begin
                st_d.row = row_dec;
                st_d.col = col_dec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign row_sel     = st_q.row;
    assign col_sel     = st_q.col;
    assign line_start  = (st_q.mode == MODE_SCAN) && st_q.col[0];
    assign frame_start = line_start && st_q.row[0];
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter int ROWS = 48,
    parameter int COLS = 48
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input logic                                          pix_en,
    input logic                                          scan_mode,
    input logic [$clog2(ROWS > COLS ? ROWS : COLS)-1:0]  row_addr,
    input logic [$clog2(ROWS > COLS ? ROWS : COLS)-1:0]  col_addr,
    input logic [ROWS-1:0]                               row_sel,
    input logic [COLS-1:0]                               col_sel,
    input logic                                          line_start,
    input logic                                          frame_start,
    input logic                                          mode_q
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1 && $countones(col_sel) == 1);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(row_sel) && $stable(col_sel) && $stable(line_start));

    p_probe_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !scan_mode && int'(row_addr) < ROWS) |=> row_sel[$past(row_addr)]);

    p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !scan_mode && int'(col_addr) >= COLS) |=> col_sel[COLS-1]);

    p_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && scan_mode && !mode_q) |=> frame_start);

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && scan_mode && mode_q && !col_sel[COLS-1])
        |=> col_sel == ($past(col_sel) << 1) && $stable(row_sel));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && scan_mode && mode_q && col_sel[COLS-1]) |=> line_start && !$stable(row_sel));

    p_marker_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start);

    p_probe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !scan_mode) |=> !line_start && !frame_start);
endmodule

bind pixel_scan_sequencer pss_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .scan_mode  (scan_mode),
    .row_addr   (row_addr),
    .col_addr   (col_addr),
    .row_sel    (row_sel),
    .col_sel    (col_sel),
    .line_start (line_start),
    .frame_start(frame_start),
    .mode_q     (st_q.mode)
);

// File: tb/pixel_scan_sequencer_tb.sv
`timescale 1ns/1ps
module pixel_scan_sequencer_tb;
    localparam int ROWS = 48;
    localparam int COLS = 48;
    localparam int AW   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pix_en = 1'b0;
    logic            scan_mode = 1'b0;
    logic [AW-1:0]   row_addr = '0;
    logic [AW-1:0]   col_addr = '0;
    logic [ROWS-1:0] row_sel;
    logic [COLS-1:0] col_sel;
    logic            line_start, frame_start;

    always #5 clk = ~clk;

    pixel_scan_sequencer #(.ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .scan_mode(scan_mode),
        .row_addr(row_addr), .col_addr(col_addr), .row_sel(row_sel),
        .col_sel(col_sel), .line_start(line_start), .frame_start(frame_start)
    );

    typedef struct {
        logic [ROWS-1:0] row;
        logic [COLS-1:0] col;
        logic            ls;
        logic            fs;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   m_scan = 0;
    int   m_r = 0;
    int   m_c = 0;

    function automatic int clamp(int v, int n);
        return (v > n - 1) ? n - 1 : v;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: one pixel-clock enable, model update, push expectation
    task automatic step(bit sm, int ra, int ca, string tag);
        exp_t e;
        @(negedge clk);
        scan_mode = sm;
        row_addr  = AW'(ra);
        col_addr  = AW'(ca);
        pix_en    = 1'b1;
        if (sm && !m_scan) begin
            m_r = 0; m_c = 0;
        end else if (sm) begin
            if (m_c == COLS - 1) begin
                m_c = 0;
                m_r = (m_r == ROWS - 1) ? 0 : m_r + 1;
            end else m_c++;
        end else begin
            m_r = clamp(ra, ROWS);
            m_c = clamp(ca, COLS);
        end
        m_scan = sm;
        e.row = ROWS'(1) << m_r;
        e.col = COLS'(1) << m_c;
        e.ls  = m_scan && (m_c == 0);
        e.fs  = m_scan && (m_c == 0) && (m_r == 0);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        pix_en = 1'b0;
    endtask

    // monitor: compare after each enabled edge
    initial begin
        forever begin
            bit en_s;
            @(posedge clk);
            en_s = pix_en;
            @(negedge clk);
            if (en_s) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected enable", 64'(1), 64'(0));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(row_sel == e.row, e.tag, "row_sel", 64'(row_sel), 64'(e.row));
                    check(col_sel == e.col, e.tag, "col_sel", 64'(col_sel), 64'(e.col));
                    check({line_start, frame_start} == {e.ls, e.fs}, e.tag, "markers",
                          64'({line_start, frame_start}), 64'({e.ls, e.fs}));
                end
            end
        end
    end

    task automatic expect_hold(string tag, int cycles);
        logic [ROWS-1:0] r0;
        logic [COLS-1:0] c0;
        logic [1:0]      m0;
        @(negedge clk);
        r0 = row_sel; c0 = col_sel; m0 = {line_start, frame_start};
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            row_addr  = AW'(i * 7 + 3);
            col_addr  = AW'(i * 11 + 1);
            scan_mode = ~scan_mode;
        end
        @(negedge clk);
        check(row_sel == r0, tag, "row held", 64'(row_sel), 64'(r0));
        check(col_sel == c0, tag, "col held", 64'(col_sel), 64'(c0));
        check({line_start, frame_start} == m0, tag, "markers held",
              64'({line_start, frame_start}), 64'(m0));
    endtask

    initial begin
        #4_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(row_sel == ROWS'(1), "R1", "row_sel", 64'(row_sel), 64'(1));
        check(col_sel == COLS'(1), "R1", "col_sel", 64'(col_sel), 64'(1));
        check({line_start, frame_start} == 2'b00, "R1", "markers",
              64'({line_start, frame_start}), 64'(0));

        // R4: probe decode
        step(0, 5, 9, "R4");
        step(0, 0, 0, "R4");
        step(0, 47, 47, "R4");
        step(0, 30, 2, "R4");
        // R5: clamp
        step(0, 50, 63, "R5");
        step(0, 48, 10, "R5");
        step(0, 3, 60, "R5");
        // R4/R10: hold while addresses and mode toggle without enable
        expect_hold("R10", 6);
        scan_mode = 1'b0;

        // R6: scan entry
        step(1, 20, 20, "R6");
        // R7/R8/R9: a full frame plus a bit, with idle gaps
        for (int k = 0; k < ROWS * COLS + 60; k++) begin
            step(1, k % 64, (k * 3) % 64, "R8");
            if (k % 500 == 7) expect_hold("R3", 2);
            scan_mode = 1'b1;
        end
        // back to probe: R9 markers low
        step(0, 12, 40, "R9");
        // R6: re-entry restarts at origin
        step(1, 0, 0, "R6");
        step(1, 0, 0, "R7");
        step(1, 0, 0, "R7");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3", "queue drained", 64'(exp_q.size()), 64'(0));
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule